// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a memory system by checking every access against a small table of protection regions. Each region is described by a base address and an attribute word. The attribute word carries an enable flag, a power-of-two size exponent, a permission code, an execute-never flag, and cacheable and shareable hints. The block receives an access address, an access kind (data read, data write or instruction fetch) and a privilege flag. One clock cycle later it reports whether the access is allowed, which region decided the result, and that region's cacheable and shareable attributes.

Regions may overlap. When they do, the enabled region with the highest number decides the result. A denied access produces a one-cycle fault pulse. The same denial also latches the offending address and sets a sticky fault flag, which stays set until software clears it. A plain write port programs the table, the global enable and the fault clear.

Top module: `mpu_checker`

## Requirements
- R1: Eight regions (0..7) are held. Attribute bit 31 enables a region, and a disabled region never matches any address.
- R2: A region spans 2^(SIZE+1) bytes, where SIZE is attribute bits [5:0]. The span is never smaller than 32 bytes, so SIZE values below 4 act as 4. An address matches when its bits above the span equal those of the base.
- R3: When several enabled regions match, the highest-numbered one wins and its number appears on `rspRegion` with `rspHit` high. With no match, `rspHit` is low and `rspRegion` is 0.
- R4: The permission code sits in attribute bits [23:21]. Code 0 allows nothing. Code 1 allows privileged read and write only. Code 2 allows privileged read and write plus unprivileged read. Code 3 allows everything. Code 5 allows privileged read only. Every other code allows nothing.
- R5: An instruction fetch is checked as a read. It is denied at both privilege levels when the winning region has attribute bit 28 (execute-never) set.
- R6: `rspCacheable` and `rspShareable` report attribute bits 16 and 18 of the winning region. Both are 0 when no region wins.
- R7: While the global enable is off, every access is allowed and no region is reported. While it is on and no region matches, privileged accesses are allowed and unprivileged ones are denied.
- R8: A request presented with `accValid` in one cycle gives `rspValid` and its result in the next cycle.
- R9: A denied access raises `faultPulse` for exactly the cycle its response is shown. It also sets `faultValid`, which stays set until a clear command, and loads `faultAddr` with the access address. A new fault in the same cycle as a clear takes precedence over the clear.
- R10: A write selects its target with `cfgKind`: 0 writes a base address, 1 writes an attribute word (both for region `cfgRegion`), 2 writes the global enable from data bit 0, and 3 clears the fault flag. After reset all regions and the global enable are off and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Write target: base, attribute, control, fault clear |
| cfgRegion | input | 3 | Region number for base and attribute writes |
| cfgData | input | 32 | Write data |
| accValid | input | 1 | Access request valid |
| accAddr | input | 32 | Access address |
| accKind | input | 2 | 0 read, 1 write, 2 fetch |
| accPriv | input | 1 | 1 for a privileged access |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspAllow | output | 1 | Access allowed |
| rspHit | output | 1 | A region matched |
| rspRegion | output | 3 | Number of the winning region |
| rspCacheable | output | 1 | Cacheable attribute of the winner |
| rspShareable | output | 1 | Shareable attribute of the winner |
| faultPulse | output | 1 | One-cycle denial pulse |
| faultValid | output | 1 | Sticky fault flag |
| faultAddr | output | 32 | Address of the most recent denied access |

## Verification
Several properties are checked by assertions on every cycle. A fault pulse always appears with a valid deny response. The fault flag stays set unless a clear arrives. Responses taken while checking is globally off are always allows. A response with no hit never carries a region number or attributes. An unprivileged miss and an execute-never fetch always raise a fault.

Other behaviours can only be shown by the bench's scenarios, which compare against an independent model:
- the size decoding and alignment boundaries;
- the highest-number priority among overlapping regions;
- every permission code in the table;
- the exact fault address that is latched;
- random programs of the table.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int ATTR_W     = 32;
  localparam int EN_BIT     = 31;
  localparam int XN_BIT     = 28;
  localparam int AP_LSB     = 21;
  localparam int SHARE_BIT  = 18;
  localparam int CACHE_BIT  = 16;
  localparam int MIN_EXP    = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_e;

  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_ATTR = 2'd1,
    CFG_CTRL = 2'd2,
    CFG_FCLR = 2'd3
  } cfgKind_e;

  typedef struct packed {
    logic baseWr;
    logic attrWr;
    logic ctrlWr;
    logic faultClr;
    logic rspLoad;
    logic allow;
    logic faultSet;
  } ctlStrobe_t;

  function automatic logic permOk(input logic [2:0] ap, input logic priv,
                                  input logic isWrite);
    case (ap)
      3'd1:    return priv;
      3'd2:    return priv | ~isWrite;
      3'd3:    return 1'b1;
      3'd5:    return priv & ~isWrite;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mpu_control.sv
module mpu_control
  import mpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgKind,
  input  logic       accValid,
  input  logic [1:0] accKind,
  input  logic       accPriv,
  input  logic       globalEn,
  input  logic       effHit,
  input  logic [2:0] winAp,
  input  logic       winXn,
  output ctlStrobe_t strb
);

  logic allowComb;

  always_comb begin
    if (!globalEn)
      allowComb = 1'b1;
    else if (!effHit)
      allowComb = accPriv;
    else if ((accKind == ACC_FETCH) && winXn)
      allowComb = 1'b0;
    else
      allowComb = permOk(winAp, accPriv, accKind == ACC_WRITE);
  end

  always_comb begin
    strb          = '0;
    strb.baseWr   = cfgWrEn && (cfgKind == CFG_BASE);
    strb.attrWr   = cfgWrEn && (cfgKind == CFG_ATTR);
    strb.ctrlWr   = cfgWrEn && (cfgKind == CFG_CTRL);
    strb.faultClr = cfgWrEn && (cfgKind == CFG_FCLR);
    strb.rspLoad  = accValid;
    strb.allow    = allowComb;
    strb.faultSet = accValid && !allowComb;
  end

  AST_NOHIT_USER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    accValid && globalEn && !effHit && !accPriv |-> strb.faultSet); // R7

  AST_XN_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    accValid && globalEn && effHit && winXn && (accKind == ACC_FETCH) |-> strb.faultSet); // R5

endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [IDX_W-1:0]  cfgRegion,
  input  logic [ATTR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              globalEn,
  output logic              effHit,
  output logic [2:0]        winAp,
  output logic              winXn,
  output logic              rspValid,
  output logic              rspAllow,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspRegion,
  output logic              rspCacheable,
  output logic              rspShareable,
  output logic              faultPulse,
  output logic              faultValid,
  output logic [ADDR_W-1:0] faultAddr
);

  logic [ADDR_W-1:0]      baseQ [NUM_REGIONS];
  logic [ATTR_W-1:0]      attrQ [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] rgnMatch;
  logic                   winHitRaw;
  logic [IDX_W-1:0]       winIdx;
  logic [ATTR_W-1:0]      winAttr;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic [6:0]        expo;
    logic [ADDR_W-1:0] mask;
    always_comb begin
      expo = {1'b0, attrQ[g][5:0]} + 7'd1;
      if (expo < 7'(MIN_EXP)) expo = 7'(MIN_EXP);
      mask = {ADDR_W{1'b1}} << expo;
      rgnMatch[g] = attrQ[g][EN_BIT] && (((accAddr ^ baseQ[g]) & mask) == '0);
    end
  end

  always_comb begin
    winHitRaw = 1'b0;
    winIdx    = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (rgnMatch[i]) begin
        winHitRaw = 1'b1;
        winIdx    = IDX_W'(i);
      end
    end
  end

  assign winAttr = attrQ[winIdx];
  assign effHit  = winHitRaw && globalEn;
  assign winAp   = winAttr[AP_LSB +: 3];
  assign winXn   = winAttr[XN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        baseQ[i] <= '0;
        attrQ[i] <= '0;
      end
      globalEn <= 1'b0;
    end else begin
      if (strb.baseWr) baseQ[cfgRegion] <= cfgData[ADDR_W-1:0];
      if (strb.attrWr) attrQ[cfgRegion] <= cfgData;
      if (strb.ctrlWr) globalEn <= cfgData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAllow     <= 1'b0;
      rspHit       <= 1'b0;
      rspRegion    <= '0;
      rspCacheable <= 1'b0;
      rspShareable <= 1'b0;
      faultPulse   <= 1'b0;
      faultValid   <= 1'b0;
      faultAddr    <= '0;
    end else begin
      rspValid   <= strb.rspLoad;
      faultPulse <= strb.faultSet;
      if (strb.rspLoad) begin
        rspAllow     <= strb.allow;
        rspHit       <= effHit;
        rspRegion    <= effHit ? winIdx : '0;
        rspCacheable <= effHit && winAttr[CACHE_BIT];
        rspShareable <= effHit && winAttr[SHARE_BIT];
      end
      if (strb.faultSet) begin
        faultValid <= 1'b1;
        faultAddr  <= accAddr;
      end else if (strb.faultClr) begin
        faultValid <= 1'b0;
      end
    end
  end

  AST_FAULT_IS_DENY: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> rspValid && !rspAllow && faultValid); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && !strb.faultClr |=> faultValid); // R9

  AST_DISABLED_ALLOW: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !$past(globalEn) |-> rspAllow && !rspHit); // R7

  AST_MISS_NO_ATTR: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> (rspRegion == '0) && !rspCacheable && !rspShareable); // R6

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgKind,
  input  logic [IDX_W-1:0]  cfgRegion,
  input  logic [31:0]       cfgData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accKind,
  input  logic              accPriv,
  output logic              rspValid,
  output logic              rspAllow,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspRegion,
  output logic              rspCacheable,
  output logic              rspShareable,
  output logic              faultPulse,
  output logic              faultValid,
  output logic [ADDR_W-1:0] faultAddr
);

  ctlStrobe_t strb;
  logic       globalEn;
  logic       effHit;
  logic [2:0] winAp;
  logic       winXn;

  mpu_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgKind  (cfgKind),
    .accValid (accValid),
    .accKind  (accKind),
    .accPriv  (accPriv),
    .globalEn (globalEn),
    .effHit   (effHit),
    .winAp    (winAp),
    .winXn    (winXn),
    .strb     (strb)
  );

  mpu_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgRegion    (cfgRegion),
    .cfgData      (cfgData),
    .accAddr      (accAddr),
    .globalEn     (globalEn),
    .effHit       (effHit),
    .winAp        (winAp),
    .winXn        (winXn),
    .rspValid     (rspValid),
    .rspAllow     (rspAllow),
    .rspHit       (rspHit),
    .rspRegion    (rspRegion),
    .rspCacheable (rspCacheable),
    .rspShareable (rspShareable),
    .faultPulse   (faultPulse),
    .faultValid   (faultValid),
    .faultAddr    (faultAddr)
  );

endmodule

// File: tb/mpu_checker_tb.sv
module mpu_checker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgKind = '0;
  logic [2:0]  cfgRegion = '0;
  logic [31:0] cfgData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accKind = '0;
  logic        accPriv = 1'b0;
  logic        rspValid, rspAllow, rspHit, rspCacheable, rspShareable;
  logic [2:0]  rspRegion;
  logic        faultPulse, faultValid;
  logic [31:0] faultAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mBase [8];
  logic [31:0] mAttr [8];
  logic        mEn = 1'b0;
  logic        mFault = 1'b0;
  logic [31:0] mFaultAddr = '0;

  always #5 clk = ~clk;

  mpu_checker u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgKind(cfgKind),
    .cfgRegion(cfgRegion), .cfgData(cfgData), .accValid(accValid),
    .accAddr(accAddr), .accKind(accKind), .accPriv(accPriv),
    .rspValid(rspValid), .rspAllow(rspAllow), .rspHit(rspHit),
    .rspRegion(rspRegion), .rspCacheable(rspCacheable),
    .rspShareable(rspShareable), .faultPulse(faultPulse),
    .faultValid(faultValid), .faultAddr(faultAddr)
  );

  function automatic logic [31:0] mkAttr(bit en, bit xn, int ap, bit s, bit c, int size);
    return (32'(en) << 31) | (32'(xn) << 28) | (32'(ap & 7) << 21) |
           (32'(s) << 18) | (32'(c) << 16) | 32'(size & 63);
  endfunction

  function automatic bit permModel(int ap, bit priv, bit wr);
    if (ap == 1) return priv;
    if (ap == 2) return priv || !wr;
    if (ap == 3) return 1;
    if (ap == 5) return priv && !wr;
    return 0;
  endfunction

  // expected packed result: {allow, hit, region[2:0], cache, share}
  function automatic logic [6:0] model(logic [31:0] addr, int kind, bit priv);
    bit hit = 0; int idx = 0; bit allow;
    for (int r = 0; r < 8; r++) begin
      int e = int'(mAttr[r][5:0]) + 1;
      logic [63:0] span;
      if (e < 5) e = 5;
      span = 64'd1 << e;
      if (mAttr[r][31] && ((64'(addr) / span) == (64'(mBase[r]) / span))) begin
        hit = 1; idx = r;
      end
    end
    if (!mEn) return 7'b1_0_000_00;
    if (!hit) return {priv, 1'b0, 3'd0, 2'b00};
    if (kind == 2 && mAttr[idx][28]) allow = 0;
    else allow = permModel(int'(mAttr[idx][23:21]), priv, kind == 1);
    return {allow, 1'b1, 3'(idx), mAttr[idx][16], mAttr[idx][18]};
  endfunction

  task automatic cfgWrite(int kind, int region, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgKind = 2'(kind); cfgRegion = 3'(region); cfgData = data;
    if (kind == 0) mBase[region] = data;
    if (kind == 1) mAttr[region] = data;
    if (kind == 2) mEn = data[0];
    if (kind == 3) mFault = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setRegion(int r, logic [31:0] base, logic [31:0] attr);
    cfgWrite(0, r, base);
    cfgWrite(1, r, attr);
  endtask

  task automatic checkAcc(string tag, logic [31:0] addr, int kind, bit priv);
    logic [6:0] exp, got;
    @(negedge clk);
    accValid = 1'b1; accAddr = addr; accKind = 2'(kind); accPriv = priv;
    exp = model(addr, kind, priv);
    if (!exp[6]) begin mFault = 1'b1; mFaultAddr = addr; end
    @(negedge clk);
    accValid = 1'b0;
    got = {rspAllow, rspHit, rspRegion, rspCacheable, rspShareable};
    checks++;
    if (!rspValid || got !== exp || faultPulse !== !exp[6] ||
        faultValid !== mFault || faultAddr !== mFaultAddr) begin
      fails++;
      $display("FAIL %s addr=%h kind=%0d priv=%0d: got v=%b res=%b fp=%b fv=%b fa=%h exp v=1 res=%b fp=%b fv=%b fa=%h",
               tag, addr, kind, priv, rspValid, got, faultPulse, faultValid, faultAddr,
               exp, !exp[6], mFault, mFaultAddr);
    end
  endtask

  task automatic checkIdle(string tag);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || faultPulse !== 1'b0 || faultValid !== mFault ||
        faultAddr !== mFaultAddr) begin
      fails++;
      $display("FAIL %s idle: got v=%b fp=%b fv=%b fa=%h exp v=0 fp=0 fv=%b fa=%h",
               tag, rspValid, faultPulse, faultValid, faultAddr, mFault, mFaultAddr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedInit;
    int apList [6] = '{0, 1, 2, 3, 5, 6};
    seedInit = int'($urandom(32'd20240611));
    for (int r = 0; r < 8; r++) begin mBase[r] = '0; mAttr[r] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    checkIdle("R10 reset");
    checkAcc("R10 reset response", 32'h0, 0, 0);

    // global off: everything allowed, even with an enabled no-access region
    setRegion(7, 32'h0000_4000, mkAttr(1, 1, 0, 1, 1, 9));
    checkAcc("R7 disabled user write", 32'h0000_4010, 1, 0);
    checkAcc("R7 disabled fetch", 32'h0000_4010, 2, 1);
    setRegion(7, 32'h0, 32'h0);
    cfgWrite(2, 0, 32'h1);

    checkAcc("R7 miss user", 32'h0000_9000, 0, 0);
    checkAcc("R7 miss priv", 32'h0000_9004, 1, 1);
    checkIdle("R9 sticky");
    cfgWrite(3, 0, 32'h0);
    checkIdle("R9 clear");

    setRegion(2, 32'h0000_2000, mkAttr(1, 0, 3, 0, 0, 9));
    setRegion(5, 32'h0000_2000, mkAttr(1, 1, 5, 1, 1, 7));
    checkAcc("R3 overlap user read", 32'h0000_2010, 0, 0);
    checkAcc("R6 overlap priv read", 32'h0000_2010, 0, 1);
    checkAcc("R4 code5 priv write", 32'h0000_2010, 1, 1);
    checkAcc("R5 xn priv fetch", 32'h0000_2010, 2, 1);
    checkAcc("R3 lower region user write", 32'h0000_2300, 1, 0);
    checkAcc("R5 fetch no xn", 32'h0000_2300, 2, 0);
    checkAcc("R2 last byte", 32'h0000_23FF, 0, 0);
    checkAcc("R2 past end", 32'h0000_2400, 0, 0);
    setRegion(5, 32'h0000_2000, mkAttr(0, 1, 5, 1, 1, 7));
    checkAcc("R1 disabled region", 32'h0000_2010, 1, 0);

    setRegion(0, 32'h0000_0100, mkAttr(1, 0, 2, 1, 0, 1));
    checkAcc("R2 min span in", 32'h0000_011F, 0, 0);
    checkAcc("R2 min span out", 32'h0000_0120, 0, 0);
    checkAcc("R4 code2 user write", 32'h0000_0104, 1, 0);
    setRegion(1, 32'h0000_0800, mkAttr(1, 0, 1, 0, 1, 4));
    checkAcc("R4 code1 user read", 32'h0000_0810, 0, 0);
    checkAcc("R4 code1 priv write", 32'h0000_0810, 1, 1);
    setRegion(3, 32'h0000_0A00, mkAttr(1, 0, 6, 0, 0, 4));
    checkAcc("R4 code6 priv read", 32'h0000_0A00, 0, 1);
    cfgWrite(2, 0, 32'h0);
    checkAcc("R7 off again", 32'h0000_0A00, 0, 0);
    cfgWrite(2, 0, 32'h1);

    for (int round = 0; round < 8; round++) begin
      for (int r = 0; r < 8; r++) begin
        int sz = 4 + int'($urandom % 9);
        logic [31:0] span = 32'd1 << (sz + 1);
        logic [31:0] b = ($urandom & 32'h0000_FFFF) & ~(span - 1);
        setRegion(r, b, mkAttr(($urandom % 4) != 0, $urandom % 2,
                               apList[$urandom % 6], $urandom % 2, $urandom % 2, sz));
      end
      for (int k = 0; k < 50; k++) begin
        int r = int'($urandom % 8);
        int sz = int'(mAttr[r][5:0]);
        logic [31:0] a;
        if (k % 8 == 7) a = $urandom & 32'h0001_FFFF;
        else a = mBase[r] + ($urandom % (32'd1 << (sz + 2)));
        checkAcc("R8 random", a, int'($urandom % 3), $urandom % 2);
        if (k % 17 == 16) begin
          cfgWrite(3, 0, 32'h0);
          checkIdle("R9 random clear");
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule